// File: doc/BRIEF.md
# Event-Driven Multi-Output PWM Timer

A single free-running up-counter feeds a bank of match comparators. Each comparator that has been enabled raises an event on a count in which its selected match value equals the counter. Any output can be driven by any event. Every output has a set mask and a clear mask over the events, and a two-bit policy decides what the output does when both masks hit in the same count. A limit mask names the events that return the counter to zero. This gives one period that all outputs share.

Software configures the block through a flat word-addressed write/read port. A typical PWM channel uses one event as the period, which is also in the limit mask, and one event as the duty. In normal polarity the period event sets the output and the duty event clears it, with the policy set to "set". In inverted polarity the two events swap roles and the policy is "clear". Each match register has a shadow. The match register loads from its shadow at each period boundary, so a new duty or period never tears a cycle. A configuration bit suppresses this reload.

Register byte addresses:
- config at 0x000
- control at 0x004
- limit at 0x008
- policy at 0x00C
- counter, read-only, at 0x010
- match at 0x100+4e
- shadow at 0x200+4e
- event word at 0x300+4e
- set mask at 0x400+4n
- clear mask at 0x480+4n

Top module: `evt_pwm_timer`

## Requirements
- R1: After reset every output is 0, the counter is 0 and all registers are 0, except the halt bit (control bit 2), which is 1. The control register therefore reads 0x4.
- R2: While halt is 1, the counter and the prescaler hold their values and no event fires.
- R3: With prescaler value P in control bits [12:5], the counter advances once every P+1 clocks.
- R4: Event e fires in a count when combine field bits [13:12] of its event word equal 1 and the match register selected by word bits [3:0] equals the counter. A word of 0, or any other combine value, disables the event.
- R5: When a fired event is in the limit mask (bit e = event e), the counter goes to 0 on that count; otherwise it increments. A period match of N-1 gives a period of N counts.
- R6: On each count, an output goes high if only its set mask hits a fired event and goes low if only its clear mask hits one. Otherwise it keeps its value, except as stated in R7.
- R7: When the set and clear masks of output n both hit in one count, policy bits [2n+1:2n] decide the result: 0 keeps the value, 1 sets, 2 clears and 3 toggles.
- R8: On a count in which the limit resets the counter, every match register loads from its shadow, unless config bit 7 is 1. A direct write to a match register takes effect at once.
- R9: A period event with match N-1 and a duty event with match D give a normal-polarity output that is high for D+1 of every N counts. Swapping the events and using policy 2 gives the complement.
- R10: Every writable register reads back the value written, within its field widths.
- R11: With no limit event, the counter wraps from its all-ones value to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| pwm_out | output | NUM_OUT | Output levels |

## Verification
The bench builds the timer with CNT_W set to 8 and keeps 16 events and 16 outputs. The narrow counter brings the wrap from all-ones to zero within a few hundred cycles, and every event and output index stays in use. Periods of ten counts, together with prescaler values of 0 and 2, make whole periods and the shadow-reload boundaries short enough to cover every conflict policy and both polarities.

// File: rtl/evt_pwm_timer.sv
module evt_pwm_timer #(
  parameter int NUM_EV  = 16,
  parameter int NUM_OUT = 16,
  parameter int CNT_W   = 32,
  parameter int PRE_W   = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_we,
  input  logic [11:0]        reg_addr,
  input  logic [31:0]        reg_wdata,
  output logic [31:0]        reg_rdata,
  output logic [NUM_OUT-1:0] pwm_out
);
  localparam int SELW = (NUM_EV > 1) ? $clog2(NUM_EV) : 1;
  localparam int OW   = (NUM_OUT > 1) ? $clog2(NUM_OUT) : 1;

  logic               noreload, halt;
  logic [PRE_W-1:0]   presc, pcnt;
  logic [NUM_EV-1:0]  limit_mask, fired;
  logic [2*NUM_OUT-1:0] policy;
  logic [CNT_W-1:0]   cnt;
  logic [CNT_W-1:0]   match_r [NUM_EV];
  logic [CNT_W-1:0]   shadow  [NUM_EV];
  logic [SELW-1:0]    ev_sel  [NUM_EV];
  logic [1:0]         ev_comb [NUM_EV];
  logic [NUM_EV-1:0]  set_mask [NUM_OUT];
  logic [NUM_EV-1:0]  clr_mask [NUM_OUT];
  logic [NUM_OUT-1:0] out_nxt;

  wire [3:0] page = reg_addr[11:8];
  wire [5:0] widx = reg_addr[7:2];
  wire [4:0] oidx = reg_addr[6:2];
  wire ev_hit  = int'(widx) < NUM_EV;
  wire out_hit = int'(oidx) < NUM_OUT;
  wire tick = !halt && (pcnt >= presc);
  wire wrap = |(fired & limit_mask);

  always_comb begin
    for (int e = 0; e < NUM_EV; e++)
      fired[e] = tick && (ev_comb[e] == 2'd1) && (int'(ev_sel[e]) < NUM_EV)
                 && (match_r[ev_sel[e]] == cnt);
  end

  always_comb begin
    for (int n = 0; n < NUM_OUT; n++) begin
      logic s, c;
      s = |(fired & set_mask[n]);
      c = |(fired & clr_mask[n]);
      out_nxt[n] = pwm_out[n];
      if (s && !c) out_nxt[n] = 1'b1;
      else if (c && !s) out_nxt[n] = 1'b0;
      else if (s && c)
        case (policy[2*n +: 2])
          2'd1: out_nxt[n] = 1'b1;
          2'd2: out_nxt[n] = 1'b0;
          2'd3: out_nxt[n] = ~pwm_out[n];
          default: out_nxt[n] = pwm_out[n];
        endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      noreload <= 1'b0; halt <= 1'b1; presc <= '0; pcnt <= '0;
      limit_mask <= '0; policy <= '0; cnt <= '0; pwm_out <= '0;
      for (int e = 0; e < NUM_EV; e++) begin
        match_r[e] <= '0; shadow[e] <= '0; ev_sel[e] <= '0; ev_comb[e] <= '0;
      end
      for (int n = 0; n < NUM_OUT; n++) begin
        set_mask[n] <= '0; clr_mask[n] <= '0;
      end
    end else begin
      if (tick) begin
        pcnt    <= '0;
        cnt     <= wrap ? '0 : cnt + 1'b1;
        pwm_out <= out_nxt;
        if (wrap && !noreload)
          for (int e = 0; e < NUM_EV; e++) match_r[e] <= shadow[e];
      end else if (!halt) begin
        pcnt <= pcnt + 1'b1;
      end
      if (reg_we) begin
        if (reg_addr == 12'h000) noreload <= reg_wdata[7];
        else if (reg_addr == 12'h004) begin
          halt  <= reg_wdata[2];
          presc <= reg_wdata[5 +: PRE_W];
        end
        else if (reg_addr == 12'h008) limit_mask <= reg_wdata[NUM_EV-1:0];
        else if (reg_addr == 12'h00C) policy <= reg_wdata[2*NUM_OUT-1:0];
        else if (page == 4'h1 && ev_hit) match_r[widx[SELW-1:0]] <= reg_wdata[CNT_W-1:0];
        else if (page == 4'h2 && ev_hit) shadow[widx[SELW-1:0]]  <= reg_wdata[CNT_W-1:0];
        else if (page == 4'h3 && ev_hit) begin
          ev_sel[widx[SELW-1:0]]  <= reg_wdata[SELW-1:0];
          ev_comb[widx[SELW-1:0]] <= reg_wdata[13:12];
        end
        else if (reg_addr[11:7] == 5'b01000 && out_hit) set_mask[oidx[OW-1:0]] <= reg_wdata[NUM_EV-1:0];
        else if (reg_addr[11:7] == 5'b01001 && out_hit) clr_mask[oidx[OW-1:0]] <= reg_wdata[NUM_EV-1:0];
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == 12'h000) reg_rdata[7] = noreload;
    else if (reg_addr == 12'h004) begin
      reg_rdata[2] = halt;
      reg_rdata[5 +: PRE_W] = presc;
    end
    else if (reg_addr == 12'h008) reg_rdata[NUM_EV-1:0] = limit_mask;
    else if (reg_addr == 12'h00C) reg_rdata[2*NUM_OUT-1:0] = policy;
    else if (reg_addr == 12'h010) reg_rdata[CNT_W-1:0] = cnt;
    else if (page == 4'h1 && ev_hit) reg_rdata[CNT_W-1:0] = match_r[widx[SELW-1:0]];
    else if (page == 4'h2 && ev_hit) reg_rdata[CNT_W-1:0] = shadow[widx[SELW-1:0]];
    else if (page == 4'h3 && ev_hit) begin
      reg_rdata[SELW-1:0] = ev_sel[widx[SELW-1:0]];
      reg_rdata[13:12]    = ev_comb[widx[SELW-1:0]];
    end
    else if (reg_addr[11:7] == 5'b01000 && out_hit) reg_rdata[NUM_EV-1:0] = set_mask[oidx[OW-1:0]];
    else if (reg_addr[11:7] == 5'b01001 && out_hit) reg_rdata[NUM_EV-1:0] = clr_mask[oidx[OW-1:0]];
  end

  assert_halt_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    halt |=> ($stable(cnt) && $stable(pcnt)));
  assert_count_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !wrap) |=> cnt == $past(cnt) + 1'b1);
  assert_limit_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> cnt == '0);
  assert_out_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (fired == '0) |=> $stable(pwm_out));
  assert_event_needs_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
    halt |-> (fired == '0));
endmodule

// File: tb/evt_pwm_timer_test.sv
module evt_pwm_timer_test;
  localparam int CW = 8;
  localparam int CMAX = (1 << CW) - 1;

  logic clk = 0, rst_n = 0, reg_we = 0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [15:0] pwm_out;

  evt_pwm_timer #(.NUM_EV(16), .NUM_OUT(16), .CNT_W(CW), .PRE_W(8)) uut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pwm_out(pwm_out));

  always #4 clk = ~clk;

  int checks = 0, fails = 0;
  bit cmp_on = 0;

  int m_cnt = 0, m_pcnt = 0, m_pre = 0, m_lim = 0, m_pol = 0;
  bit m_halt = 1, m_nr = 0;
  int m_match[16], m_shadow[16], m_evw[16], m_set[16], m_clr[16];
  bit [15:0] m_out = '0;

  task automatic model_reset();
    m_cnt = 0; m_pcnt = 0; m_pre = 0; m_lim = 0; m_pol = 0; m_halt = 1; m_nr = 0; m_out = '0;
    for (int i = 0; i < 16; i++) begin
      m_match[i] = 0; m_shadow[i] = 0; m_evw[i] = 0; m_set[i] = 0; m_clr[i] = 0;
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) model_reset();
    else begin
      bit tk;
      bit [15:0] fev, nout;
      fev = '0; nout = m_out;
      tk = !m_halt && (m_pcnt >= m_pre);
      if (tk) begin
        for (int e = 0; e < 16; e++)
          if (((m_evw[e] >> 12) & 3) == 1 && m_match[m_evw[e] & 15] == m_cnt) fev[e] = 1;
        for (int n = 0; n < 16; n++) begin
          bit s, c;
          s = (fev & m_set[n]) != 0;
          c = (fev & m_clr[n]) != 0;
          if (s && !c) nout[n] = 1;
          else if (c && !s) nout[n] = 0;
          else if (s && c) begin
            int p;
            p = (m_pol >> (2 * n)) & 3;
            if (p == 1) nout[n] = 1;
            else if (p == 2) nout[n] = 0;
            else if (p == 3) nout[n] = ~m_out[n];
          end
        end
        m_pcnt = 0;
        if ((fev & m_lim) != 0) begin
          m_cnt = 0;
          if (!m_nr) for (int e = 0; e < 16; e++) m_match[e] = m_shadow[e];
        end else m_cnt = (m_cnt + 1) & CMAX;
        m_out = nout;
      end else if (!m_halt) m_pcnt = m_pcnt + 1;
      if (reg_we) begin
        int a, d;
        a = reg_addr; d = reg_wdata;
        if (a == 'h000) m_nr = d[7];
        else if (a == 'h004) begin m_halt = d[2]; m_pre = (d >> 5) & 255; end
        else if (a == 'h008) m_lim = d & 'hFFFF;
        else if (a == 'h00C) m_pol = d;
        else if (a >= 'h100 && a < 'h140) m_match[(a - 'h100) / 4] = d & CMAX;
        else if (a >= 'h200 && a < 'h240) m_shadow[(a - 'h200) / 4] = d & CMAX;
        else if (a >= 'h300 && a < 'h340) m_evw[(a - 'h300) / 4] = d & 'h300F;
        else if (a >= 'h400 && a < 'h440) m_set[(a - 'h400) / 4] = d & 'hFFFF;
        else if (a >= 'h480 && a < 'h4C0) m_clr[(a - 'h480) / 4] = d & 'hFFFF;
      end
    end
  end

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk)
    if (rst_n && cmp_on) chk("R6 outputs vs model", pwm_out, m_out);

  task automatic wr(input int a, input int d);
    @(negedge clk); reg_we = 1; reg_addr = a[11:0]; reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic rd(input int a, output int v);
    reg_addr = a[11:0]; #1; v = reg_rdata;
  endtask

  task automatic highs(input int n, input int cyc, output int h);
    h = 0;
    repeat (cyc) begin @(negedge clk); h += pwm_out[n]; end
  endtask

  initial begin
    #(200000 * 8);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int v, h;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    rd('h004, v); chk("R1 control after reset", v, 'h4);
    rd('h010, v); chk("R1 counter after reset", v, 0);
    chk("R1 outputs after reset", pwm_out, 0);
    rd('h100, v); chk("R1 match reset", v, 0);
    cmp_on = 1;

    wr('h004, 0);
    repeat (300) @(negedge clk);
    rd('h010, v); chk("R11 counter wraps vs model", v, m_cnt);

    wr('h004, 'h4);
    rd('h010, v);
    repeat (10) @(negedge clk);
    begin int v2; rd('h010, v2); chk("R2 counter held while halted", v2, v); end

    wr('h100, 9);  wr('h200, 9);
    wr('h104, 2);  wr('h204, 2);
    wr('h108, 3);  wr('h208, 3);
    wr('h10C, 5);  wr('h20C, 5);
    wr('h300, 'h1000);
    wr('h304, 'h1001);
    wr('h308, 'h0000);
    wr('h30C, 'h2003);
    wr('h008, 1);
    wr('h400, 1); wr('h480, 2);
    wr('h404, 2); wr('h484, 1);
    wr('h408, 1); wr('h488, 1);
    wr('h40C, 1); wr('h48C, 1);
    wr('h410, 'hC);
    wr('h00C, 'h39);
    wr('h004, 0);
    repeat (300) @(negedge clk);
    highs(0, 30, h); chk("R9 normal polarity high counts", h, 9);
    highs(1, 30, h); chk("R9 inverted polarity high counts", h, 21);
    highs(2, 40, h); chk("R7 toggle policy high counts", h, 20);
    highs(3, 30, h); chk("R7 keep policy holds low", h, 0);
    highs(4, 30, h); chk("R4 disabled events never fire", h, 0);
    rd('h30C, v); chk("R4 event word readback", v, 'h2003);

    wr('h204, 9);
    repeat (30) @(negedge clk);
    rd('h104, v); chk("R8 match reloaded from shadow", v, 9);
    highs(0, 30, h); chk("R7 set policy at equal match", h, 30);
    highs(1, 30, h); chk("R7 clear policy at equal match", h, 0);

    wr('h000, 'h80);
    wr('h204, 2);
    repeat (30) @(negedge clk);
    rd('h104, v); chk("R8 reload suppressed", v, 9);

    wr('h104, 2);
    rd('h104, v); chk("R8 direct match write", v, 2);
    wr('h004, 2 << 5);
    repeat (90) @(negedge clk);
    highs(0, 90, h); chk("R3 prescaled duty high counts", h, 27);
    rd('h010, v); chk("R5 counter vs model", v, m_cnt);
    chk("R5 counter within period", (v <= 9) ? 1 : 0, 1);

    rd('h008, v); chk("R10 limit readback", v, 1);
    rd('h00C, v); chk("R10 policy readback", v, 'h39);
    rd('h304, v); chk("R10 event word readback", v, 'h1001);
    rd('h400, v); chk("R10 set mask readback", v, 1);
    rd('h484, v); chk("R10 clear mask readback", v, 1);
    rd('h004, v); chk("R10 control readback", v, 'h40);
    rd('h000, v); chk("R10 config readback", v, 'h80);
    rd('h20C, v); chk("R10 shadow readback", v, 5);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule